// File: doc/BRIEF.md
# Descriptor Ring Pair Controller

This block sits between software and a processing engine and manages two circular descriptor rings. Software places job descriptors in the inbound ring and reports how many it placed through a count write. The controller hands those descriptors to the engine one at a time, in the order they were posted. For each finished job it writes a completion entry into the outbound ring. Software then retires the completion entries with a second count write.

Neither side sees the other's head or tail pointer. Software works from two counts that the controller keeps: the number of free inbound slots, and the number of filled outbound slots. A two-bit status word holds a completion-pending bit and an error bit. Each bit is cleared by writing a 1 to it. A small error code says what went wrong. The interrupt line is raised while either status bit is set.

Ring bases are live inputs and the ring depth is a parameter. Dispatch only happens while the enable input is high. The engine is driven through a start/done handshake, with the descriptor address presented on start.

Top module: `jr_ring_ctrl`

## Requirements
- R1: After reset, `slots_avail` equals DEPTH, `slots_full` is 0, `status` is 0, `err_code` is 0, `irq` is low and `eng_start` is low.
- R2: An `add_we` with `add_n` no larger than `slots_avail` posts `add_n` descriptors. In the next cycle `slots_avail` is lower by `add_n` and higher by 1 if a dispatch happened in the same cycle.
- R3: An `add_we` with `add_n` larger than `slots_avail` posts nothing and leaves `slots_avail` unchanged apart from dispatch. It sets status bit 1 (error) in the next cycle and reports error code 1.
- R4: Descriptors are dispatched in posting order. The k-th dispatch presents `in_base + (k mod DEPTH) * DESC_BYTES` on `eng_desc_addr`, so the index wraps modulo DEPTH.
- R5: `eng_start` pulses for one cycle only under four conditions: `ring_en` is high, a posted descriptor is waiting, no job is in flight, and `slots_full` is below DEPTH. A second start never comes before the engine's done.
- R6: An `eng_done` while a job is in flight makes three things happen in the same cycle: `out_wr_valid` is asserted, `out_wr_addr` is `out_base + (j mod DEPTH) * DESC_BYTES` for the j-th completion, and `out_wr_data` is the finished job's descriptor address. Then `slots_full` rises by 1 and status bit 0 (completion pending) is set.
- R7: An `rmv_we` with `rmv_n` no larger than `slots_full` reduces `slots_full` by `rmv_n`. A larger `rmv_n` removes nothing, sets the error bit and reports error code 2.
- R8: A `clr_we` clears the status bits whose `clr_mask` bit is 1 (bit 0 completion, bit 1 error). A set in the same cycle wins over the clear. `irq` is high exactly when either status bit is set.
- R9: `err_code` keeps the code of the first error until the error bit is cleared. An add error and a remove error in the same cycle give code 3.
- R10: An `eng_done` with no job in flight is ignored: there is no outbound write and `slots_full` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_en | input | 1 | Channel enable; dispatch only while high |
| in_base | input | ADDR_W | Inbound ring base address |
| out_base | input | ADDR_W | Outbound ring base address |
| add_we | input | 1 | Add-job write strobe |
| add_n | input | CNT_W | Number of descriptors posted |
| rmv_we | input | 1 | Removed-job write strobe |
| rmv_n | input | CNT_W | Number of outbound entries retired |
| clr_we | input | 1 | Status clear write strobe |
| clr_mask | input | 2 | Write-1-to-clear mask for the status bits |
| slots_avail | output | CNT_W | Free inbound slots |
| slots_full | output | CNT_W | Filled outbound slots |
| status | output | 2 | Bit 0 completion pending, bit 1 error |
| err_code | output | 2 | 1 add overflow, 2 remove underflow, 3 both |
| irq | output | 1 | Interrupt, OR of the status bits |
| eng_start | output | 1 | Start pulse to the engine |
| eng_desc_addr | output | ADDR_W | Address of the dispatched descriptor |
| eng_done | input | 1 | Engine completion pulse |
| out_wr_valid | output | 1 | Outbound entry write strobe |
| out_wr_addr | output | ADDR_W | Outbound slot address |
| out_wr_data | output | ADDR_W | Completed descriptor address |

## Verification
The bench goes after several corner cases:
- Adds that exceed the free count by exactly one. A design that accepted them would let the posted count run past DEPTH and corrupt the inbound index.
- Removes of one more than the filled count. If these were accepted, `slots_full` would wrap to a huge value.
- Done pulses with no job in flight. These would create phantom completions.
- Clears in the same cycle as a new completion. If the clear won, the completion interrupt would be lost.

Long random runs fill the outbound ring to DEPTH so that dispatch has to stall. They also carry both ring indices through several wraps, which exposes an address that is not taken modulo the ring size. Changing the enable mid-stream checks that nothing leaves the ring while the channel is off.

// File: rtl/jr_pkg.sv
package jr_pkg;
   localparam int unsigned STAT_DONE_BIT = 0;
   localparam int unsigned STAT_ERR_BIT  = 1;

   typedef enum logic [1:0] {
      JR_ERR_NONE = 2'd0,
      JR_ERR_ADD  = 2'd1,
      JR_ERR_RMV  = 2'd2,
      JR_ERR_BOTH = 2'd3
   } jr_err_e;
endpackage

// File: rtl/jr_in_ring.sv
module jr_in_ring #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned CNT_W = $clog2(DEPTH + 1),
   parameter int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             add_we,
   input  logic [CNT_W-1:0] add_n,
   input  logic             take,
   output logic [CNT_W-1:0] avail,
   output logic             pend_nz,
   output logic [IDX_W-1:0] rd_idx,
   output logic             add_err
);
   logic [CNT_W-1:0] avail_q, pend_q, acc_n;
   logic [IDX_W-1:0] rd_q;
   logic             accept;

   assign add_err = add_we && (add_n > avail_q);
   assign accept  = add_we && !add_err;
   assign acc_n   = accept ? add_n : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         avail_q <= CNT_W'(DEPTH);
         pend_q  <= '0;
         rd_q    <= '0;
      end else begin
         avail_q <= avail_q - acc_n + CNT_W'(take);
         pend_q  <= pend_q + acc_n - CNT_W'(take);
         if (take) rd_q <= rd_q + 1'b1;
      end
   end

   assign avail   = avail_q;
   assign pend_nz = (pend_q != '0);
   assign rd_idx  = rd_q;
endmodule

// File: rtl/jr_out_ring.sv
module jr_out_ring #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned CNT_W = $clog2(DEPTH + 1),
   parameter int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             put,
   input  logic             rmv_we,
   input  logic [CNT_W-1:0] rmv_n,
   output logic [CNT_W-1:0] full,
   output logic             room,
   output logic [IDX_W-1:0] wr_idx,
   output logic             rmv_err
);
   logic [CNT_W-1:0] full_q, rm_n;
   logic [IDX_W-1:0] wr_q;

   assign rmv_err = rmv_we && (rmv_n > full_q);
   assign rm_n    = (rmv_we && !rmv_err) ? rmv_n : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q <= '0;
         wr_q   <= '0;
      end else begin
         full_q <= full_q - rm_n + CNT_W'(put);
         if (put) wr_q <= wr_q + 1'b1;
      end
   end

   assign full   = full_q;
   assign room   = (full_q < CNT_W'(DEPTH));
   assign wr_idx = wr_q;
endmodule

// File: rtl/jr_status.sv
module jr_status
   import jr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_done,
   input  logic       add_err,
   input  logic       rmv_err,
   input  logic       clr_we,
   input  logic [1:0] clr_mask,
   output logic [1:0] status,
   output logic [1:0] err_code,
   output logic       irq
);
   logic    done_q, err_q, err_keep, done_keep;
   jr_err_e code_q, new_code;

   always_comb begin
      case ({rmv_err, add_err})
         2'b01:   new_code = JR_ERR_ADD;
         2'b10:   new_code = JR_ERR_RMV;
         2'b11:   new_code = JR_ERR_BOTH;
         default: new_code = JR_ERR_NONE;
      endcase
   end

   assign err_keep  = err_q  && !(clr_we && clr_mask[STAT_ERR_BIT]);
   assign done_keep = done_q && !(clr_we && clr_mask[STAT_DONE_BIT]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         code_q <= JR_ERR_NONE;
      end else begin
         done_q <= done_keep || set_done;
         err_q  <= err_keep || (new_code != JR_ERR_NONE);
         code_q <= err_keep ? code_q : new_code;
      end
   end

   assign status[STAT_DONE_BIT] = done_q;
   assign status[STAT_ERR_BIT]  = err_q;
   assign err_code = code_q;
   assign irq      = done_q | err_q;
endmodule

// File: rtl/jr_ring_ctrl.sv
module jr_ring_ctrl #(
   parameter int unsigned DEPTH      = 16,
   parameter int unsigned DESC_BYTES = 32,
   parameter int unsigned ADDR_W     = 32,
   localparam int unsigned CNT_W     = $clog2(DEPTH + 1),
   localparam int unsigned IDX_W     = $clog2(DEPTH),
   localparam int unsigned SHIFT     = $clog2(DESC_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ring_en,
   input  logic [ADDR_W-1:0] in_base,
   input  logic [ADDR_W-1:0] out_base,
   input  logic              add_we,
   input  logic [CNT_W-1:0]  add_n,
   input  logic              rmv_we,
   input  logic [CNT_W-1:0]  rmv_n,
   input  logic              clr_we,
   input  logic [1:0]        clr_mask,
   output logic [CNT_W-1:0]  slots_avail,
   output logic [CNT_W-1:0]  slots_full,
   output logic [1:0]        status,
   output logic [1:0]        err_code,
   output logic              irq,
   output logic              eng_start,
   output logic [ADDR_W-1:0] eng_desc_addr,
   input  logic              eng_done,
   output logic              out_wr_valid,
   output logic [ADDR_W-1:0] out_wr_addr,
   output logic [ADDR_W-1:0] out_wr_data
);
   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two of at least 2");
      assert ((DESC_BYTES & (DESC_BYTES - 1)) == 0 && DESC_BYTES >= 1)
         else $error("DESC_BYTES must be a power of two");
      assert (ADDR_W > IDX_W + SHIFT)
         else $error("ADDR_W too narrow for ring span");
   end

   logic             pend_nz, room, take, put, add_err, rmv_err;
   logic             busy_q;
   logic [IDX_W-1:0] rd_idx, wr_idx;
   logic [ADDR_W-1:0] in_off, out_off, cur_q;

   jr_in_ring #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_in (
      .clk(clk), .rst_n(rst_n), .add_we(add_we), .add_n(add_n),
      .take(take), .avail(slots_avail), .pend_nz(pend_nz),
      .rd_idx(rd_idx), .add_err(add_err)
   );

   jr_out_ring #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_out (
      .clk(clk), .rst_n(rst_n), .put(put), .rmv_we(rmv_we),
      .rmv_n(rmv_n), .full(slots_full), .room(room),
      .wr_idx(wr_idx), .rmv_err(rmv_err)
   );

   jr_status u_stat (
      .clk(clk), .rst_n(rst_n), .set_done(put), .add_err(add_err),
      .rmv_err(rmv_err), .clr_we(clr_we), .clr_mask(clr_mask),
      .status(status), .err_code(err_code), .irq(irq)
   );

   generate
      if (SHIFT == 0) begin : g_unit_stride
         assign in_off  = ADDR_W'(rd_idx);
         assign out_off = ADDR_W'(wr_idx);
      end else begin : g_scaled_stride
         assign in_off  = ADDR_W'({rd_idx, {SHIFT{1'b0}}});
         assign out_off = ADDR_W'({wr_idx, {SHIFT{1'b0}}});
      end
   endgenerate

   // one job in flight; outbound must have space for its completion
   assign take = ring_en && pend_nz && !busy_q && room;
   assign put  = busy_q && eng_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cur_q  <= '0;
      end else begin
         if (take) begin
            busy_q <= 1'b1;
            cur_q  <= in_base + in_off;
         end else if (put) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign eng_start     = take;
   assign eng_desc_addr = in_base + in_off;
   assign out_wr_valid  = put;
   assign out_wr_addr   = out_base + out_off;
   assign out_wr_data   = cur_q;
endmodule

// File: rtl/jr_ring_ctrl_chk.sv
module jr_ring_ctrl_chk #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ring_en,
   input logic             add_we,
   input logic [CNT_W-1:0] add_n,
   input logic             rmv_we,
   input logic [CNT_W-1:0] slots_avail,
   input logic [CNT_W-1:0] slots_full,
   input logic [1:0]       status,
   input logic             eng_start,
   input logic             out_wr_valid
);
   assert_avail_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      slots_avail <= CNT_W'(DEPTH));

   assert_add_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (add_we && (add_n > slots_avail)) |=> status[1]);

   assert_start_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> ring_en);

   assert_start_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> (slots_full < CNT_W'(DEPTH)));

   assert_single_flight_R5: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);

   assert_full_incr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_wr_valid && !rmv_we) |=> (slots_full == $past(slots_full) + 1'b1));

   assert_done_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_wr_valid |=> status[0]);

   assert_full_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      slots_full <= CNT_W'(DEPTH));
endmodule

bind jr_ring_ctrl jr_ring_ctrl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ring_en(ring_en), .add_we(add_we),
   .add_n(add_n), .rmv_we(rmv_we), .slots_avail(slots_avail),
   .slots_full(slots_full), .status(status), .eng_start(eng_start),
   .out_wr_valid(out_wr_valid)
);

// File: tb/jr_ring_ctrl_bench.sv
module jr_ring_ctrl_bench;
   localparam int DEPTH = 8;
   localparam int DB    = 32;
   localparam int AW    = 32;
   localparam int CW    = $clog2(DEPTH + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic ring_en = 1'b0, add_we = 1'b0, rmv_we = 1'b0, clr_we = 1'b0, eng_done = 1'b0;
   logic [CW-1:0] add_n = '0, rmv_n = '0;
   logic [1:0]    clr_mask = '0;
   logic [AW-1:0] in_base = 32'h0001_0000, out_base = 32'h0002_0000;
   logic [CW-1:0] slots_avail, slots_full;
   logic [1:0]    status, err_code;
   logic          irq, eng_start, out_wr_valid;
   logic [AW-1:0] eng_desc_addr, out_wr_addr, out_wr_data;

   always #10 clk = ~clk;

   jr_ring_ctrl #(.DEPTH(DEPTH), .DESC_BYTES(DB), .ADDR_W(AW)) u_jr_ring_ctrl (
      .clk(clk), .rst_n(rst_n), .ring_en(ring_en), .in_base(in_base),
      .out_base(out_base), .add_we(add_we), .add_n(add_n), .rmv_we(rmv_we),
      .rmv_n(rmv_n), .clr_we(clr_we), .clr_mask(clr_mask),
      .slots_avail(slots_avail), .slots_full(slots_full), .status(status),
      .err_code(err_code), .irq(irq), .eng_start(eng_start),
      .eng_desc_addr(eng_desc_addr), .eng_done(eng_done),
      .out_wr_valid(out_wr_valid), .out_wr_addr(out_wr_addr),
      .out_wr_data(out_wr_data)
   );

   int checks = 0, errors = 0;
   // reference state, derived from the requirements
   int m_avail, m_pend, m_rd, m_busy, m_cur, m_wr, m_full, m_done, m_err, m_code;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_avail = DEPTH; m_pend = 0; m_rd = 0; m_busy = 0; m_cur = 0;
      m_wr = 0; m_full = 0; m_done = 0; m_err = 0; m_code = 0;
   endtask

   function automatic bit exp_start();
      return ring_en && m_pend > 0 && !m_busy && m_full < DEPTH;
   endfunction

   task automatic compare();
      int st;
      chk(int'(slots_avail) == m_avail, "R2 slots_avail", int'(slots_avail), m_avail);
      chk(int'(slots_full) == m_full, "R7 slots_full", int'(slots_full), m_full);
      chk(eng_start == exp_start(), "R5 eng_start", int'(eng_start), int'(exp_start()));
      if (exp_start())
         chk(eng_desc_addr == in_base + AW'(m_rd * DB), "R4 eng_desc_addr",
             int'(eng_desc_addr), int'(in_base) + m_rd * DB);
      chk(out_wr_valid == (m_busy && eng_done), "R6 out_wr_valid",
          int'(out_wr_valid), int'(m_busy && eng_done));
      if (m_busy && eng_done) begin
         chk(out_wr_addr == out_base + AW'(m_wr * DB), "R6 out_wr_addr",
             int'(out_wr_addr), int'(out_base) + m_wr * DB);
         chk(int'(out_wr_data) == m_cur, "R6 out_wr_data", int'(out_wr_data), m_cur);
      end
      st = m_err * 2 + m_done;
      chk(int'(status) == st, "R8 status", int'(status), st);
      chk(irq == (st != 0), "R8 irq", int'(irq), int'(st != 0));
      chk(int'(err_code) == m_code, "R9 err_code", int'(err_code), m_code);
   endtask

   task automatic model_next();
      bit aerr, rerr, tk, dn, ekeep, dkeep;
      int acc, rm, nc;
      aerr = add_we && int'(add_n) > m_avail;
      rerr = rmv_we && int'(rmv_n) > m_full;
      acc  = (add_we && !aerr) ? int'(add_n) : 0;
      rm   = (rmv_we && !rerr) ? int'(rmv_n) : 0;
      tk   = exp_start();
      dn   = m_busy && eng_done;
      nc   = (aerr ? 1 : 0) + (rerr ? 2 : 0);
      ekeep = m_err && !(clr_we && clr_mask[1]);
      dkeep = m_done && !(clr_we && clr_mask[0]);
      if (tk) begin m_cur = int'(in_base) + m_rd * DB; m_rd = (m_rd + 1) % DEPTH; end
      if (dn) m_wr = (m_wr + 1) % DEPTH;
      m_avail = m_avail - acc + (tk ? 1 : 0);
      m_pend  = m_pend + acc - (tk ? 1 : 0);
      m_full  = m_full - rm + (dn ? 1 : 0);
      m_busy  = tk ? 1 : (dn ? 0 : m_busy);
      m_code  = ekeep ? m_code : nc;
      m_err   = (ekeep || nc != 0) ? 1 : 0;
      m_done  = (dkeep || dn) ? 1 : 0;
   endtask

   task automatic tick();
      #1;
      compare();
      model_next();
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      add_we = 0; rmv_we = 0; clr_we = 0; eng_done = 0; add_n = '0; rmv_n = '0; clr_mask = '0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240613));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      #1;
      chk(int'(slots_avail) == DEPTH, "R1 reset avail", int'(slots_avail), DEPTH);
      chk(slots_full == '0 && status == '0 && err_code == '0, "R1 reset status",
          int'(status), 0);
      chk(!irq && !eng_start, "R1 reset irq/start", int'(irq), 0);
      @(negedge clk);

      // R5: posting while disabled dispatches nothing
      add_we = 1; add_n = CW'(3); tick();
      idle_inputs();
      repeat (4) tick();
      chk(int'(slots_avail) == DEPTH - 3, "R5 disabled hold", int'(slots_avail), DEPTH - 3);

      // R10: done with nothing in flight is ignored
      eng_done = 1; tick(); eng_done = 0; tick();
      chk(slots_full == '0 && !out_wr_valid, "R10 spurious done", int'(slots_full), 0);

      // R3: add one more than free slots
      add_we = 1; add_n = CW'(DEPTH - 2); tick(); idle_inputs(); tick();
      chk(status[1] && err_code == 2'd1, "R3 add overflow", int'(err_code), 1);

      // R7: remove more than filled
      clr_we = 1; clr_mask = 2'b10; tick(); idle_inputs();
      rmv_we = 1; rmv_n = CW'(1); tick(); idle_inputs(); tick();
      chk(status[1] && err_code == 2'd2, "R7 remove underflow", int'(err_code), 2);

      // R9: both errors in one cycle after clearing
      clr_we = 1; clr_mask = 2'b10; tick(); idle_inputs();
      add_we = 1; add_n = CW'(DEPTH); rmv_we = 1; rmv_n = CW'(2); tick(); idle_inputs();
      add_we = 1; add_n = CW'(DEPTH); tick(); idle_inputs(); tick();
      chk(err_code == 2'd3, "R9 first code held", int'(err_code), 3);
      clr_we = 1; clr_mask = 2'b10; tick(); idle_inputs();

      // R6/R8: enable, complete one job while clearing completion in same cycle
      ring_en = 1; tick(); tick();
      eng_done = 1; clr_we = 1; clr_mask = 2'b01; tick(); idle_inputs(); tick();
      chk(status[0] && irq, "R8 set beats clear", int'(status), 1);

      // random phase: wraps, full outbound stall, enable toggles
      for (int i = 0; i < 6000; i++) begin
         int r;
         idle_inputs();
         r = int'($urandom_range(0, 99));
         if (r < 12) begin add_we = 1; add_n = CW'($urandom_range(0, m_avail + 1)); end
         r = int'($urandom_range(0, 99));
         if (r < ((i / 1000) % 2 == 0 ? 4 : 15)) begin
            rmv_we = 1; rmv_n = CW'($urandom_range(0, m_full + 1));
         end
         eng_done = ($urandom_range(0, 99) < 35);
         if ($urandom_range(0, 99) < 5) begin clr_we = 1; clr_mask = 2'($urandom_range(0, 3)); end
         if ($urandom_range(0, 199) == 0) ring_en = ~ring_en;
         if (i == 5000) ring_en = 1;
         tick();
      end
      idle_inputs();
      tick();
      finish_run();
   end
endmodule